// File: doc/BRIEF.md
# Multiplexed Eight-Digit Lock Message Display

This block drives a time-multiplexed seven-segment display for a keypad lock. Once per clock it enables exactly one digit through an active-low select bus and presents that digit's segment pattern. The digit rotates on every clock, so a 1 kHz clock refreshes the whole display at 125 Hz.

The lock controller supplies three things: a prompt selector, three message flags (open, error, lockout), and the entry buffer with a count of the digits entered so far. While no message flag is set, the block shows the entry screen. The two leftmost digits carry a two-letter prompt. The six digits to their right carry the entered digits, with the newest on the right, and unfilled places show dashes.

Every glyph comes from a small set: the digits 0 to 5, the letters P, E and N, and a dash. The letter O is drawn with the pattern of the digit 0.

Top module: `lock_scan_display`

## Requirements
- R1: While `rst_n` is low, `digit_sel_n` is all ones (no digit enabled) and `seg` is all zeros.
- R2: From the first clock edge after reset is released, exactly one bit of `digit_sel_n` is low.
- R3: Digit 0 (the rightmost, select bit 0) is enabled first after reset. Each clock then moves to digit i+1, and digit 7 wraps back to digit 0.
- R4: `seg` is ordered g..a (bit 6 = g, bit 0 = a), and a 1 lights a segment. The patterns are: 0=0111111, 1=0000110, 2=1011011, 3=1001111, 4=1100110, 5=1101101, P=1110011, E=1111001, N=0110111, dash=1000000.
- R5: The `digit_sel_n` and `seg` values seen after a clock edge are computed from the inputs sampled at that same edge. There is one register stage.
- R6: On the entry screen, digit k (k = 0..5) shows nibble `entry[4k+3:4k]` when k < `entry_count`. Nibble 0 holds the newest digit.
- R7: On the entry screen, digits k >= `entry_count` show a dash. An `entry_count` above 6 is treated as 6.
- R8: An entry nibble with a value above 5 is shown as a dash.
- R9: The prompt occupies digit 7 and digit 6, and digit 6 is always P. For digit 7, `prompt_sel` 0 gives P, 1 gives O, 2 gives N, and 3 gives P.
- R10: With `show_open` set, digits 7..0 show dash, dash, O, P, E, N, dash, dash.
- R11: With `show_error` set, digits 5..2 show E and the other four digits show a dash.
- R12: With `show_lockout` set, all eight digits show E.
- R13: Priority is lockout, then error, then open, then the entry screen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; the digit advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prompt_sel | input | 2 | Prompt letter choice for the entry screen |
| show_open | input | 1 | Display the open message |
| show_error | input | 1 | Display the error message |
| show_lockout | input | 1 | Display the lockout message |
| entry | input | 24 | Six 4-bit digits; bits 3:0 hold the newest digit |
| entry_count | input | 3 | Number of digits entered so far |
| digit_sel_n | output | 8 | Active-low digit enables; bit 0 is the rightmost digit |
| seg | output | 7 | Segment pattern g..a, active high |

## Verification
The port never shows a whole screen at once. Any single glyph is visible only in the one cycle its digit is enabled, and it reflects the inputs sampled at that edge. The bench therefore holds a screen's inputs steady for a full eight-cycle rotation. After each edge it decodes which digit is enabled, then compares the segments against the glyph that digit should carry. The hardest cases are message-priority conflicts and input changes in mid-rotation. For these, flags are combined within one rotation, and lockout is pulsed for a single edge, so the very next digit must already show the entry view again.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

   typedef enum logic [3:0] {
      GL_0    = 4'd0,
      GL_1    = 4'd1,
      GL_2    = 4'd2,
      GL_3    = 4'd3,
      GL_4    = 4'd4,
      GL_5    = 4'd5,
      GL_P    = 4'd6,
      GL_E    = 4'd7,
      GL_N    = 4'd8,
      GL_DASH = 4'd9
   } glyph_e;

   localparam int SEG_W = 7;

   // Segment order g..a, active high.
   function automatic logic [SEG_W-1:0] glyph_seg(input glyph_e g);
      logic [SEG_W-1:0] s;
      case (g)
         GL_0:    s = 7'b0111111;
         GL_1:    s = 7'b0000110;
         GL_2:    s = 7'b1011011;
         GL_3:    s = 7'b1001111;
         GL_4:    s = 7'b1100110;
         GL_5:    s = 7'b1101101;
         GL_P:    s = 7'b1110011;
         GL_E:    s = 7'b1111001;
         GL_N:    s = 7'b0110111;
         default: s = 7'b1000000;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/lsd_scan_counter.sv
module lsd_scan_counter #(
   parameter int NUM_DIGITS = 8,
   localparam int IDX_W = $clog2(NUM_DIGITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_DIGITS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx <= '0;
      else if (idx == LAST)
         idx <= '0;
      else
         idx <= idx + 1'b1;
   end
endmodule

// File: rtl/lsd_glyph_select.sv
module lsd_glyph_select
   import lsd_pkg::*;
#(
   parameter int NUM_DIGITS   = 8,
   parameter int ENTRY_DIGITS = 6,
   parameter int NIBBLE_W     = 4,
   localparam int IDX_W = $clog2(NUM_DIGITS),
   localparam int CNT_W = $clog2(ENTRY_DIGITS + 1)
) (
   input  logic [IDX_W-1:0]             idx,
   input  logic [1:0]                   prompt_sel,
   input  logic                         show_open,
   input  logic                         show_error,
   input  logic                         show_lockout,
   input  logic [ENTRY_DIGITS*NIBBLE_W-1:0] entry,
   input  logic [CNT_W-1:0]             entry_count,
   output glyph_e                       glyph
);
   localparam int MSG_LO = (NUM_DIGITS - 4) / 2;
   localparam int MAX_NIB = 5;

   logic [NIBBLE_W-1:0] nib [NUM_DIGITS];
   int unsigned         cnt_eff;
   int unsigned         pos;

   for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_nib
      if (k < ENTRY_DIGITS) begin : g_real
         assign nib[k] = entry[k*NIBBLE_W +: NIBBLE_W];
      end else begin : g_pad
         assign nib[k] = '1;
      end
   end

   always_comb begin
      pos     = int'(idx);
      cnt_eff = (int'(entry_count) > ENTRY_DIGITS) ? ENTRY_DIGITS : int'(entry_count);
      glyph   = GL_DASH;
      if (show_lockout) begin
         glyph = GL_E;
      end else if (show_error) begin
         if (pos >= MSG_LO && pos <= MSG_LO + 3) glyph = GL_E;
      end else if (show_open) begin
         if (pos == MSG_LO + 3)      glyph = GL_0;
         else if (pos == MSG_LO + 2) glyph = GL_P;
         else if (pos == MSG_LO + 1) glyph = GL_E;
         else if (pos == MSG_LO)     glyph = GL_N;
      end else if (pos == NUM_DIGITS - 1) begin
         case (prompt_sel)
            2'd1:    glyph = GL_0;
            2'd2:    glyph = GL_N;
            default: glyph = GL_P;
         endcase
      end else if (pos == NUM_DIGITS - 2) begin
         glyph = GL_P;
      end else if (pos < cnt_eff && int'(nib[idx]) <= MAX_NIB) begin
         glyph = glyph_e'(nib[idx]);
      end
   end
endmodule

// File: rtl/lock_scan_display.sv
module lock_scan_display
   import lsd_pkg::*;
#(
   parameter int NUM_DIGITS   = 8,
   parameter int ENTRY_DIGITS = 6,
   parameter int NIBBLE_W     = 4,
   localparam int IDX_W = $clog2(NUM_DIGITS),
   localparam int CNT_W = $clog2(ENTRY_DIGITS + 1)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [1:0]                       prompt_sel,
   input  logic                             show_open,
   input  logic                             show_error,
   input  logic                             show_lockout,
   input  logic [ENTRY_DIGITS*NIBBLE_W-1:0] entry,
   input  logic [CNT_W-1:0]                 entry_count,
   output logic [NUM_DIGITS-1:0]            digit_sel_n,
   output logic [SEG_W-1:0]                 seg
);
   if (NUM_DIGITS != ENTRY_DIGITS + 2) begin : g_bad_split
      $error("lock_scan_display: NUM_DIGITS must equal ENTRY_DIGITS + 2");
   end
   if (NUM_DIGITS < 4) begin : g_bad_digits
      $error("lock_scan_display: at least four digits are needed for messages");
   end
   if (NIBBLE_W < 3) begin : g_bad_nibble
      $error("lock_scan_display: NIBBLE_W must hold the values 0..5");
   end

   logic [IDX_W-1:0]      idx;
   glyph_e                glyph;
   logic [NUM_DIGITS-1:0] sel_next;

   lsd_scan_counter #(.NUM_DIGITS(NUM_DIGITS)) u_scan (
      .clk   (clk),
      .rst_n (rst_n),
      .idx   (idx)
   );

   lsd_glyph_select #(
      .NUM_DIGITS   (NUM_DIGITS),
      .ENTRY_DIGITS (ENTRY_DIGITS),
      .NIBBLE_W     (NIBBLE_W)
   ) u_glyph (
      .idx          (idx),
      .prompt_sel   (prompt_sel),
      .show_open    (show_open),
      .show_error   (show_error),
      .show_lockout (show_lockout),
      .entry        (entry),
      .entry_count  (entry_count),
      .glyph        (glyph)
   );

   for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_sel
      assign sel_next[i] = (idx != IDX_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         digit_sel_n <= '1;
         seg         <= '0;
      end else begin
         digit_sel_n <= sel_next;
         seg         <= glyph_seg(glyph);
      end
   end
endmodule

// File: rtl/lsd_checker.sv
module lsd_checker #(
   parameter int NUM_DIGITS = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [1:0]            prompt_sel,
   input logic                  show_open,
   input logic                  show_error,
   input logic                  show_lockout,
   input logic [NUM_DIGITS-1:0] digit_sel_n,
   input logic [6:0]            seg
);
   localparam logic [6:0] PAT_E = 7'b1111001;
   localparam logic [6:0] PAT_P = 7'b1110011;

   always @(negedge clk) begin
      if (!rst_n) begin
         assert_reset_blank_R1: assert (digit_sel_n == '1 && seg == '0)
            else $error("R1: outputs not blank in reset");
      end
   end

   assert_one_digit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ($countones(~digit_sel_n) == 1))
      else $error("R2: not exactly one digit enabled");

   assert_scan_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && digit_sel_n != '1) |=>
         (digit_sel_n == {$past(digit_sel_n[NUM_DIGITS-2:0]), $past(digit_sel_n[NUM_DIGITS-1])}))
      else $error("R3: scan did not advance by one digit");

   assert_lockout_all_e_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(show_lockout)) |-> (seg == PAT_E))
      else $error("R12: lockout glyph is not E");

   assert_prompt_p_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!show_lockout && !show_error && !show_open && prompt_sel == 2'd0)
       && !digit_sel_n[NUM_DIGITS-1]) |-> (seg == PAT_P))
      else $error("R9: unlock prompt letter is not P");
endmodule

bind lock_scan_display lsd_checker #(.NUM_DIGITS(NUM_DIGITS)) u_lsd_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .prompt_sel   (prompt_sel),
   .show_open    (show_open),
   .show_error   (show_error),
   .show_lockout (show_lockout),
   .digit_sel_n  (digit_sel_n),
   .seg          (seg)
);

// File: tb/lock_scan_display_bench.sv
module lock_scan_display_bench;
   localparam logic [6:0] S0 = 7'b0111111, S1 = 7'b0000110, S2 = 7'b1011011,
                          S3 = 7'b1001111, S4 = 7'b1100110, S5 = 7'b1101101,
                          SP = 7'b1110011, SE = 7'b1111001, SN = 7'b0110111,
                          SD = 7'b1000000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic [1:0]  prompt_sel = 2'd0;
   logic        show_open = 1'b0, show_error = 1'b0, show_lockout = 1'b0;
   logic [23:0] entry = '0;
   logic [2:0]  entry_count = '0;
   logic [7:0]  digit_sel_n;
   logic [6:0]  seg;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;

   lock_scan_display u_lock_scan_display (
      .clk(clk), .rst_n(rst_n), .prompt_sel(prompt_sel), .show_open(show_open),
      .show_error(show_error), .show_lockout(show_lockout), .entry(entry),
      .entry_count(entry_count), .digit_sel_n(digit_sel_n), .seg(seg)
   );

   function automatic logic [6:0] digit_pat(input int v);
      case (v)
         0: return S0; 1: return S1; 2: return S2;
         3: return S3; 4: return S4; 5: return S5;
         default: return SD;
      endcase
   endfunction

   function automatic logic [6:0] expect_seg(input int d);
      int n;
      int c;
      if (show_lockout) return SE;
      if (show_error) return (d >= 2 && d <= 5) ? SE : SD;
      if (show_open) begin
         case (d)
            5: return S0; 4: return SP; 3: return SE; 2: return SN;
            default: return SD;
         endcase
      end
      if (d == 7) return (prompt_sel == 2'd1) ? S0 : (prompt_sel == 2'd2) ? SN : SP;
      if (d == 6) return SP;
      c = (entry_count > 3'd6) ? 6 : int'(entry_count);
      if (d >= c) return SD;
      n = int'(entry[d*4 +: 4]);
      return digit_pat(n);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic int sel_index(input logic [7:0] s);
      for (int i = 0; i < 8; i++) if (s[i] == 1'b0) return i;
      return -1;
   endfunction

   // One full rotation: every digit checked against the expected glyph.
   task automatic check_frame(input string req);
      for (int k = 0; k < 8; k++) begin
         @(posedge clk);
         @(negedge clk);
         check({req, " one-hot"}, 32'($countones(~digit_sel_n)), 32'd1);
         check(req, {25'd0, seg}, {25'd0, expect_seg(sel_index(digit_sel_n))});
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 sel", {24'd0, digit_sel_n}, 32'h000000FF);
      check("R1 seg", {25'd0, seg}, 32'd0);
   endtask

   task automatic t_rotate;
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 16; k++) begin
         @(posedge clk);
         @(negedge clk);
         check("R3 order", {24'd0, digit_sel_n}, {24'd0, ~(8'd1 << (k % 8))});
      end
   endtask

   task automatic t_entry;
      prompt_sel = 2'd0; entry_count = 3'd0; entry = 24'h543210;
      check_frame("R7 empty");
      entry_count = 3'd3;
      check_frame("R6 partial");
      entry_count = 3'd6;
      check_frame("R4 R6 full");
      entry = 24'h012345; entry_count = 3'd7;
      check_frame("R7 count clamp");
      entry = 24'h9F6A31; entry_count = 3'd6;
      check_frame("R8 invalid nibble");
   endtask

   task automatic t_prompts;
      entry = 24'h000421; entry_count = 3'd2;
      for (int p = 1; p < 4; p++) begin
         prompt_sel = 2'(p);
         check_frame("R9 prompt");
      end
      prompt_sel = 2'd0;
   endtask

   task automatic t_messages;
      show_open = 1'b1;
      check_frame("R10 open");
      show_open = 1'b0; show_error = 1'b1;
      check_frame("R11 error");
      show_error = 1'b0; show_lockout = 1'b1;
      check_frame("R12 lockout");
      show_open = 1'b1; show_error = 1'b1;
      check_frame("R13 lockout wins");
      show_lockout = 1'b0;
      check_frame("R13 error over open");
      show_error = 1'b0;
      entry_count = 3'd6;
      check_frame("R13 open over entry");
      show_open = 1'b0;
   endtask

   task automatic t_latency;
      entry = 24'h555555; entry_count = 3'd6; prompt_sel = 2'd0;
      @(negedge clk);
      show_lockout = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R5 lockout same edge", {25'd0, seg}, {25'd0, SE});
      show_lockout = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R5 release same edge", {25'd0, seg}, {25'd0, expect_seg(sel_index(digit_sel_n))});
   endtask

   initial begin
      #1 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      t_reset();
      t_rotate();
      t_entry();
      t_prompts();
      t_messages();
      t_latency();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 8);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule